// File: doc/BRIEF.md
# Register-Pair Immediate Word Adder

This block carries out a single instruction: it adds a 6-bit unsigned constant to a 16-bit value held in two neighbouring bytes of an external register file. The low byte sits in an even register and the high byte in the odd register just above it. Only four pairs can be reached: registers 24/25, 26/27, 28/29 and 30/31.

A controller presents the instruction word and the current status byte together with a one-cycle start strobe. The block then spends two cycles on the register file through one byte read port and one byte write port. In the first cycle it reads the low byte, adds the constant and writes the low byte back. In the second cycle it reads the high byte, adds the saved carry and writes the high byte back.

One cycle later it pulses done and presents the new status byte. In that byte, carry and overflow are taken from the sign of the high byte before and after the add, and zero covers the full 16-bit result.

Top module: `pairadd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o and rf_we_o are 0 and sreg_o is 8'h00.
- R2: A start is accepted only when instr_i[15:8] equals 8'h96. Any other word with start_i high is ignored: busy_o stays 0 and nothing is written.
- R3: The low register is 24 + 2*instr_i[5:4] and the high register is that number plus one. The constant K is {instr_i[7:6], instr_i[3:0]}, giving 0 to 63.
- R4: In the cycle after an accepted start, busy_o is 1 and the low register is read and written. In the next cycle busy_o is 1 and the high register is read and written. In the cycle after that, busy_o is 0 and done_o is 1 for exactly one cycle.
- R5: After the operation the pair holds (old pair + K) mod 65536. With K = 0 both bytes are written back unchanged.
- R6: Status bit positions are C=0, Z=1, N=2, V=3, S=4. C = old bit 15 and not new bit 15. V = new bit 15 and not old bit 15. N = new bit 15. S = N xor V.
- R7: Z is 1 only when all 16 result bits are 0. A pair of 16'hFFFF plus 1 gives 16'h0000 with C=1 and Z=1. A zero low byte under a nonzero high byte gives Z=0.
- R8: sreg_o[7:5] equals sreg_i[7:5] as sampled with the accepted start, whatever sreg_i does afterwards.
- R9: start_i is ignored while busy_o is 1. Such a start causes no extra busy cycle and no write to any other register.
- R10: sreg_o changes only in a cycle where done_o is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| instr_i | input | 16 | Instruction word, sampled with start |
| sreg_i | input | 8 | Current status byte, sampled with start |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data, same cycle as address |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |
| busy_o | output | 1 | High during the two working cycles |
| done_o | output | 1 | One-cycle pulse after the high byte is written |
| sreg_o | output | 8 | Updated status byte |

## Verification
The bench builds the block with its default parameters: byte-wide data, a 5-bit register address, a 6-bit constant and a base register of 24. With these values all four pairs and the full range of the constant can be reached, so the random stimulus covers every pair select and every K from 0 to 63. It also covers high-byte sign crossings in both directions. Directed cases add the full wrap to zero and the 16'h7FFF to 16'h8000 overflow. They also cover a zero low byte under a nonzero high byte, a foreign opcode, and a second start held through the busy window.

// File: rtl/pairadd_pkg.sv
package pairadd_pkg;

    localparam int BYTE_W     = 8;
    localparam int RF_AW      = 5;
    localparam int IMM_W      = 6;
    localparam int SEL_W      = 2;
    localparam int INSTR_W    = 16;
    localparam int BASE_REG   = 24;
    localparam logic [7:0] OPC_HI = 8'h96;

    // status byte bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] sel;
        logic [IMM_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic              cout;
        logic [BYTE_W-1:0] sum;
    } add_res_t;

    function automatic dec_t decode_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.hit = (w[15:8] == OPC_HI);
        d.sel = w[5:4];
        d.imm = {w[7:6], w[3:0]};
        return d;
    endfunction

    function automatic logic [RF_AW-1:0] low_reg(input logic [SEL_W-1:0] sel);
        return RF_AW'(BASE_REG) + RF_AW'({sel, 1'b0});
    endfunction

endpackage

// File: rtl/pairadd_decode.sv
module pairadd_decode
    import pairadd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    always_comb dec_o = decode_word(instr_i);
endmodule

// File: rtl/pairadd_byte_add.sv
module pairadd_byte_add
    import pairadd_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output add_res_t     res_o
);
    logic [W:0] full;
    always_comb begin
        full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        res_o = {full[W], full[W-1:0]};
    end
endmodule

// File: rtl/pairadd_flags.sv
module pairadd_flags
    import pairadd_pkg::*;
(
    input  logic [BYTE_W-1:0] base_i,      // status byte latched with start
    input  logic              old_msb_i,   // high byte sign before the add
    input  logic              new_msb_i,   // high byte sign after the add
    input  logic              lo_zero_i,
    input  logic              hi_zero_i,
    output logic [BYTE_W-1:0] sreg_o
);
    logic v;
    always_comb begin
        v            = new_msb_i & ~old_msb_i;
        sreg_o       = base_i;
        sreg_o[FL_C] = old_msb_i & ~new_msb_i;
        sreg_o[FL_Z] = lo_zero_i & hi_zero_i;
        sreg_o[FL_N] = new_msb_i;
        sreg_o[FL_V] = v;
        sreg_o[FL_S] = new_msb_i ^ v;
    end
endmodule

// File: rtl/pairadd_seq.sv
module pairadd_seq
    import pairadd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [BYTE_W-1:0]  sreg_i,
    output logic [RF_AW-1:0]   rf_raddr_o,
    input  logic [BYTE_W-1:0]  rf_rdata_i,
    output logic               rf_we_o,
    output logic [RF_AW-1:0]   rf_waddr_o,
    output logic [BYTE_W-1:0]  rf_wdata_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [BYTE_W-1:0]  sreg_o
);

    seq_state_e        state_q;
    logic [SEL_W-1:0]  sel_q;
    logic [IMM_W-1:0]  imm_q;
    logic [BYTE_W-1:0] base_q;
    logic              carry_q;
    logic              lo_zero_q;
    logic [BYTE_W-1:0] sreg_q;
    logic              done_q;

    dec_t              dec;
    add_res_t          add_res;
    logic [BYTE_W-1:0] add_b;
    logic              add_cin;
    logic [RF_AW-1:0]  cur_addr;
    logic [BYTE_W-1:0] flags_next;

    pairadd_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    // one byte adder shared by both cycles: constant in the low cycle, carry in the high
    always_comb begin
        add_b   = (state_q == ST_LOW) ? {{(BYTE_W-IMM_W){1'b0}}, imm_q} : '0;
        add_cin = (state_q == ST_HIGH) ? carry_q : 1'b0;
    end

    pairadd_byte_add #(.W(BYTE_W)) u_add (
        .a_i   (rf_rdata_i),
        .b_i   (add_b),
        .cin_i (add_cin),
        .res_o (add_res)
    );

    pairadd_flags u_flags (
        .base_i    (base_q),
        .old_msb_i (rf_rdata_i[BYTE_W-1]),
        .new_msb_i (add_res.sum[BYTE_W-1]),
        .lo_zero_i (lo_zero_q),
        .hi_zero_i (add_res.sum == '0),
        .sreg_o    (flags_next)
    );

    always_comb begin
        cur_addr   = low_reg(sel_q) + ((state_q == ST_HIGH) ? RF_AW'(1) : RF_AW'(0));
        rf_raddr_o = cur_addr;
        rf_waddr_o = cur_addr;
        rf_wdata_o = add_res.sum;
        rf_we_o    = (state_q != ST_IDLE);
        busy_o     = (state_q != ST_IDLE);
        done_o     = done_q;
        sreg_o     = sreg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sel_q     <= '0;
            imm_q     <= '0;
            base_q    <= '0;
            carry_q   <= 1'b0;
            lo_zero_q <= 1'b0;
            sreg_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && dec.hit) begin
                        sel_q   <= dec.sel;
                        imm_q   <= dec.imm;
                        base_q  <= sreg_i;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    carry_q   <= add_res.cout;
                    lo_zero_q <= (add_res.sum == '0);
                    state_q   <= ST_HIGH;
                end
                ST_HIGH: begin
                    sreg_q  <= flags_next;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> busy_o); // R4
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |=> !busy_o); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R4
    AST_FIRST_WRITE_EVEN: assert property (@(posedge clk) disable iff (rst)
        $rose(rf_we_o) |-> (!rf_waddr_o[0] && rf_waddr_o >= RF_AW'(BASE_REG))); // R3
    AST_SECOND_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && $past(rf_we_o)) |-> (rf_waddr_o == $past(rf_waddr_o) + RF_AW'(1))); // R3
    AST_CV_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !(sreg_o[FL_C] && sreg_o[FL_V])); // R6
    AST_ZERO_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (done_o && sreg_o[FL_Z]) |-> (!sreg_o[FL_N] && !sreg_o[FL_S])); // R7
    AST_SREG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(sreg_o)); // R10

endmodule

// File: tb/tb_pairadd_seq.sv
module tb_pairadd_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [7:0]  sreg_i = '0;
    logic [4:0]  rf_raddr_o, rf_waddr_o;
    logic [7:0]  rf_rdata_i, rf_wdata_o, sreg_o;
    logic        rf_we_o, busy_o, done_o;

    logic [7:0]  rf [32];
    logic        ld_we = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pairadd_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i), .sreg_i(sreg_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .busy_o(busy_o),
        .done_o(done_o), .sreg_o(sreg_o)
    );

    assign rf_rdata_i = rf[rf_raddr_o];

    always @(posedge clk) begin
        if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
        if (ld_we)   rf[ld_addr]    <= ld_data;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sreg(input logic [15:0] old, input logic [5:0] k,
                                            input logic [7:0] sin);
        logic [15:0] res;
        logic c, v, n, z;
        res = old + {10'd0, k};
        c = old[15] & ~res[15];
        v = ~old[15] & res[15];
        n = res[15];
        z = (res == 16'h0000);
        return {sin[7:5], n ^ v, v, n, z, c};
    endfunction

    function automatic logic [15:0] mk_instr(input logic [1:0] sel, input logic [5:0] k);
        return {8'h96, k[5:4], sel, k[3:0]};
    endfunction

    task automatic load_byte(input logic [4:0] a, input logic [7:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic set_pair(input logic [1:0] sel, input logic [15:0] v);
        load_byte(5'd24 + {2'b0, sel, 1'b0}, v[7:0]);
        load_byte(5'd25 + {2'b0, sel, 1'b0}, v[15:8]);
    endtask

    function automatic logic [15:0] get_pair(input logic [1:0] sel);
        logic [4:0] lo;
        lo = 5'd24 + {2'b0, sel, 1'b0};
        return {rf[lo + 5'd1], rf[lo]};
    endfunction

    // runs one accepted operation; with hold set, start stays high with alt_sel during busy
    task automatic run_op(input logic [1:0] sel, input logic [5:0] k, input logic [7:0] sin,
                          input bit hold, input logic [1:0] alt_sel);
        logic [15:0] old, res, alt_old;
        logic [4:0]  lo;
        logic [7:0]  exp_s, prev_s;
        lo      = 5'd24 + {2'b0, sel, 1'b0};
        old     = get_pair(sel);
        alt_old = get_pair(alt_sel);
        res     = old + {10'd0, k};
        exp_s   = exp_sreg(old, k, sin);
        start_i = 1'b1; instr_i = mk_instr(sel, k); sreg_i = sin;
        @(negedge clk);
        chk(busy_o == 1'b1, "R4", "busy low cycle", busy_o, 1);
        chk(rf_we_o && rf_waddr_o == lo, "R3", "low write addr", rf_waddr_o, lo);
        chk(rf_wdata_o == res[7:0], "R5", "low write data", rf_wdata_o, res[7:0]);
        start_i = hold; instr_i = mk_instr(alt_sel, 6'd37); sreg_i = ~sin;
        @(negedge clk);
        chk(busy_o == 1'b1, "R4", "busy high cycle", busy_o, 1);
        chk(rf_we_o && rf_waddr_o == lo + 5'd1, "R3", "high write addr", rf_waddr_o, lo + 5'd1);
        chk(done_o == 1'b0, "R4", "done early", done_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b0 && done_o == 1'b1, "R4", "done pulse", {busy_o, done_o}, 2'b01);
        chk(get_pair(sel) == res, "R5", "pair result", get_pair(sel), res);
        chk(sreg_o[4:0] == exp_s[4:0], "R6", "arith flags", sreg_o, exp_s);
        chk(sreg_o[1] == exp_s[1], "R7", "zero flag", sreg_o[1], exp_s[1]);
        chk(sreg_o[7:5] == sin[7:5], "R8", "kept bits", sreg_o[7:5], sin[7:5]);
        if (hold && alt_sel != sel)
            chk(get_pair(alt_sel) == alt_old, "R9", "other pair untouched", get_pair(alt_sel), alt_old);
        prev_s = sreg_o;
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R9", "no extra busy", {busy_o, done_o}, 0);
        chk(sreg_o == prev_s, "R10", "sreg holds", sreg_o, prev_s);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) rf[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && rf_we_o == 0, "R1", "reset outputs",
            {busy_o, done_o, rf_we_o}, 0);
        chk(sreg_o == 8'h00, "R1", "reset sreg", sreg_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && sreg_o == 8'h00, "R1", "after reset",
            {busy_o, done_o, sreg_o}, 0);

        // R7: full wrap to zero
        set_pair(2'd0, 16'hFFFF);
        run_op(2'd0, 6'd1, 8'hA0, 0, 2'd0);
        // R6: positive to negative overflow
        set_pair(2'd1, 16'h7FFF);
        run_op(2'd1, 6'd1, 8'h40, 0, 2'd1);
        // R7: zero low byte, nonzero high byte
        set_pair(2'd2, 16'h00FF);
        run_op(2'd2, 6'd1, 8'hE0, 0, 2'd2);
        // R5: K = 0 leaves the pair unchanged
        set_pair(2'd3, 16'hBEEF);
        run_op(2'd3, 6'd0, 8'h20, 0, 2'd3);
        chk(get_pair(2'd3) == 16'hBEEF, "R5", "K zero unchanged", get_pair(2'd3), 16'hBEEF);
        // R9: start held through busy aimed at another pair
        set_pair(2'd1, 16'h1234);
        set_pair(2'd2, 16'h5555);
        run_op(2'd1, 6'd63, 8'h00, 1, 2'd2);

        // R2: foreign opcode ignored
        set_pair(2'd0, 16'h0102);
        start_i = 1'b1; instr_i = 16'h9713;
        @(negedge clk);
        chk(busy_o == 0 && rf_we_o == 0, "R2", "foreign opcode", {busy_o, rf_we_o}, 0);
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 0 && get_pair(2'd0) == 16'h0102, "R2", "foreign no effect",
            get_pair(2'd0), 16'h0102);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [1:0]  s;
            logic [5:0]  k;
            logic [15:0] v;
            s = 2'($urandom_range(0, 3));
            k = 6'($urandom_range(0, 63));
            case ($urandom_range(0, 3))
                0: v = 16'hFFFF - 16'($urandom_range(0, 70));
                1: v = 16'h7FFF - 16'($urandom_range(0, 70));
                default: v = 16'($urandom);
            endcase
            set_pair(s, v);
            run_op(s, k, 8'($urandom), n[0], 2'($urandom_range(0, 3)));
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule